// File: doc/BRIEF.md
# Streaming 3x3 Neighbourhood Filter

This block filters a raster-ordered stream of 8-bit greyscale pixels through a 3x3 neighbourhood. It accepts one pixel per cycle whenever `in_valid` is high and produces one filtered pixel per accepted pixel once the window is primed. Two row stores, each one line long and chained, supply the two rows above the current one. A three-stage shift register per row turns the three row values into a 3x3 window. One of four kernels is applied to that window: box blur, gradient magnitude, relief (emboss) and crisp (sharpen).

The window is anchored at its bottom-right corner. The output for the input pixel at row r, column c is computed from rows r-2..r and columns c-2..c. Taps whose column would fall left of column 0 read as zero. The kernel is chosen per frame: `mode_sel` is captured together with the start-of-frame pixel. The end-of-line flag travels through the same pipeline as the data. The block suits preview and simple enhancement paths in a video pipeline, where a divide-free, root-free kernel is enough.

Top module: `fwin_filter`

## Requirements
- R1: While reset is held and directly after it is released, `out_valid` and `out_eol` are 0 and `out_pix` is 0.
- R2: The output for an input pixel accepted at rising edge k appears on the outputs after rising edge k+2. Its window holds, top row first (oldest) and left column first (oldest), the pixels at rows r-2, r-1, r and columns c-2, c-1, c.
- R3: Row and column are counted from the pixel carrying `in_sof` (row 0, column 0). The column returns to 0 after a pixel carrying `in_eol`. `out_valid` is produced for exactly those accepted pixels with row ≥ 2 that are not columns 0 or 1 of row 2, that is, after two full lines and three pixels.
- R4: Window taps at columns c-2 or c-1 that are below 0 contribute zero.
- R5: Mode 0 (blur) outputs the sum of the nine taps shifted right by `BLUR_SHIFT` (3 by default).
- R6: Mode 1 (gradient) outputs |Gx|+|Gy|. Gx weights the columns left to right as -1, 0, +1 (middle row doubled). Gy weights the rows top to bottom as -1, 0, +1 (middle column doubled).
- R7: Mode 2 (relief) outputs the weighted sum with rows top to bottom of [-2 -1 0], [-1 1 1], [0 1 2], plus 128.
- R8: Mode 3 (crisp) outputs five times the centre tap minus the four edge-adjacent taps.
- R9: Every result is clamped to 0..255.
- R10: `mode_sel` is captured only with a valid pixel carrying `in_sof`. Changes at other times do not affect the frame in progress.
- R11: `out_eol` is high exactly on the output produced from an input carrying `in_eol`, and never without `out_valid`.
- R12: Cycles with `in_valid` low change neither the window, the counters nor the row stores. They only delay the following outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Kernel for the next frame: 0 blur, 1 gradient, 2 relief, 3 crisp |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_eol | input | 1 | Input pixel is the last of its line |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Filtered pixel present |
| out_pix | output | PIX_W | Filtered pixel value |
| out_eol | output | 1 | Filtered pixel closes a line |

## Verification
The hardest case to reach from the ports is the first two columns of each row after row 2. There the shift registers still hold the tail of the previous line, and only the zero-fill masking keeps that stale data out of the result. This state occurs only after a line wrap, with a specific kernel active. The bench therefore uses lines only six pixels wide and five rows tall, so every frame wraps several times. It sweeps all four kernels across ramp, pseudo-random, saturated and checkerboard images. Extra frames change `mode_sel` right after the start-of-frame pixel and insert idle cycles between pixels, so that mode latching and stalls are exercised at those wrap points.

// File: rtl/fwin_pkg.sv
package fwin_pkg;

   typedef enum logic [1:0] {
      KM_BLUR   = 2'd0,
      KM_EDGE   = 2'd1,
      KM_RELIEF = 2'd2,
      KM_CRISP  = 2'd3
   } kmode_t;

endpackage

// File: rtl/fwin_rowstore.sv
module fwin_rowstore #(
   parameter int PIX_W = 8,
   parameter int DEPTH = 320,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    addr,
   input  logic [PIX_W-1:0] din,
   output logic [PIX_W-1:0] dout
);

   logic [PIX_W-1:0] mem [DEPTH];

   // read returns the value stored one line earlier at this column
   assign dout = mem[addr];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[addr] <= din;
         // R3
         addr_range_chk: assert ({1'b0, addr} < (AW+1)'(DEPTH));
      end
   end

endmodule

// File: rtl/fwin_window.sv
module fwin_window #(
   parameter int PIX_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         shift_en,
   input  logic [PIX_W-1:0]             row_new,
   input  logic [PIX_W-1:0]             row_mid,
   input  logic [PIX_W-1:0]             row_old,
   output logic [2:0][2:0][PIX_W-1:0]   taps
);

   // taps[i][j]: i = 0 oldest row, j = 0 oldest column
   logic [PIX_W-1:0] feed [3];

   assign feed[0] = row_old;
   assign feed[1] = row_mid;
   assign feed[2] = row_new;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taps <= '0;
      end else if (shift_en) begin
         for (int i = 0; i < 3; i++) begin
            taps[i][0] <= taps[i][1];
            taps[i][1] <= taps[i][2];
            taps[i][2] <= feed[i];
         end
      end
   end

   // R12
   win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(taps));

endmodule

// File: rtl/fwin_kernel.sv
module fwin_kernel
   import fwin_pkg::*;
#(
   parameter int PIX_W      = 8,
   parameter int BLUR_SHIFT = 3
) (
   input  kmode_t                      mode,
   input  logic [2:0][2:0][PIX_W-1:0]  taps,
   input  logic                        keep_c0,
   input  logic                        keep_c1,
   output logic [PIX_W-1:0]            result
);

   localparam int ACC_W = PIX_W + 6;
   typedef logic signed [ACC_W-1:0] acc_t;
   localparam acc_t BIAS = acc_t'(1 << (PIX_W - 1));
   localparam acc_t TOP  = acc_t'((1 << PIX_W) - 1);

   generate
      if (BLUR_SHIFT != 3 && BLUR_SHIFT != 4) begin : g_bad_shift
         $error("BLUR_SHIFT must be 3 or 4");
      end
      if (PIX_W < 4 || PIX_W > 12) begin : g_bad_pix
         $error("PIX_W out of supported range");
      end
   endgenerate

   acc_t v [3][3];

   // zero-fill taps left of column 0
   generate
      for (genvar i = 0; i < 3; i++) begin : g_row
         assign v[i][0] = keep_c0 ? acc_t'({1'b0, taps[i][0]}) : '0;
         assign v[i][1] = keep_c1 ? acc_t'({1'b0, taps[i][1]}) : '0;
         assign v[i][2] = acc_t'({1'b0, taps[i][2]});
      end
   endgenerate

   acc_t box_sum, gx, gy, ax, ay, relief, crisp, pick;

   always_comb begin
      box_sum = v[0][0] + v[0][1] + v[0][2]
              + v[1][0] + v[1][1] + v[1][2]
              + v[2][0] + v[2][1] + v[2][2];
      gx = (v[0][2] + (v[1][2] <<< 1) + v[2][2])
         - (v[0][0] + (v[1][0] <<< 1) + v[2][0]);
      gy = (v[2][0] + (v[2][1] <<< 1) + v[2][2])
         - (v[0][0] + (v[0][1] <<< 1) + v[0][2]);
      ax = gx[ACC_W-1] ? -gx : gx;
      ay = gy[ACC_W-1] ? -gy : gy;
      relief = v[1][1] + v[1][2] + v[2][1] + (v[2][2] <<< 1)
             - (v[0][0] <<< 1) - v[0][1] - v[1][0] + BIAS;
      crisp = (v[1][1] <<< 2) + v[1][1]
            - v[0][1] - v[1][0] - v[1][2] - v[2][1];
      case (mode)
         KM_BLUR:   pick = box_sum >>> BLUR_SHIFT;
         KM_EDGE:   pick = ax + ay;
         KM_RELIEF: pick = relief;
         default:   pick = crisp;
      endcase
      if (pick < 0)
         result = '0;
      else if (pick > TOP)
         result = '1;
      else
         result = pick[PIX_W-1:0];
   end

   // R9
   always_comb begin
      if (taps == '0 && mode != KM_RELIEF)
         flat_zero_chk: assert (result == '0);
   end

endmodule

// File: rtl/fwin_filter.sv
module fwin_filter
   import fwin_pkg::*;
#(
   parameter int PIX_W      = 8,
   parameter int LINE_W     = 320,
   parameter int BLUR_SHIFT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_sel,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eol,
   input  logic [PIX_W-1:0] in_pix,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_pix,
   output logic             out_eol
);

   localparam int AW = $clog2(LINE_W);

   generate
      if (LINE_W < 4) begin : g_bad_line
         $error("LINE_W must be at least 4");
      end
   endgenerate

   // position of the pixel on the input this cycle
   logic [AW-1:0] col_q, cur_col;
   logic [1:0]    row_q, cur_row;
   logic          emit;

   always_comb begin
      cur_col = in_sof ? '0 : col_q;
      cur_row = in_sof ? 2'd0 : row_q;
      emit    = in_valid && (cur_row >= 2'd2)
                && (cur_row == 2'd3 || cur_col >= AW'(2));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (in_valid) begin
         if (in_eol) begin
            col_q <= '0;
            row_q <= (cur_row == 2'd3) ? 2'd3 : cur_row + 2'd1;
         end else begin
            col_q <= cur_col + AW'(1);
            row_q <= cur_row;
         end
      end
   end

   // chained row stores: row_tap[k] is the pixel k lines above
   logic [PIX_W-1:0] row_tap [3];
   assign row_tap[0] = in_pix;

   generate
      for (genvar g = 1; g < 3; g++) begin : g_store
         fwin_rowstore #(.PIX_W(PIX_W), .DEPTH(LINE_W)) u_store (
            .clk   (clk),
            .wr_en (in_valid),
            .addr  (cur_col),
            .din   (row_tap[g-1]),
            .dout  (row_tap[g])
         );
      end
   endgenerate

   logic [2:0][2:0][PIX_W-1:0] taps;

   fwin_window #(.PIX_W(PIX_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_valid),
      .row_new  (row_tap[0]),
      .row_mid  (row_tap[1]),
      .row_old  (row_tap[2]),
      .taps     (taps)
   );

   // stage 1: side information aligned with the window registers
   logic   win_vld, win_eol, keep_c0, keep_c1;
   kmode_t mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_vld <= 1'b0;
         win_eol <= 1'b0;
         keep_c0 <= 1'b0;
         keep_c1 <= 1'b0;
         mode_q  <= KM_BLUR;
      end else begin
         win_vld <= emit;
         win_eol <= emit && in_eol;
         if (in_valid) begin
            keep_c0 <= cur_col >= AW'(2);
            keep_c1 <= cur_col != '0;
         end
         if (in_valid && in_sof)
            mode_q <= kmode_t'(mode_sel);
      end
   end

   logic [PIX_W-1:0] result;

   fwin_kernel #(.PIX_W(PIX_W), .BLUR_SHIFT(BLUR_SHIFT)) u_kern (
      .mode    (mode_q),
      .taps    (taps),
      .keep_c0 (keep_c0),
      .keep_c1 (keep_c1),
      .result  (result)
   );

   // stage 2: output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_eol   <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= win_vld;
         out_eol   <= win_eol;
         if (win_vld)
            out_pix <= result;
      end
   end

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   // R11
   eol_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eol |-> out_valid);

   // R10
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_sof) |=> $stable(mode_q));

endmodule

// File: tb/fwin_filter_test.sv
`timescale 1ns/1ps
module fwin_filter_test;

   localparam int LW = 6;
   localparam int NR = 5;
   localparam int SH = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'd0;
   logic       in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
   logic [7:0] in_pix = 8'd0;
   logic       out_valid, out_eol;
   logic [7:0] out_pix;

   fwin_filter #(.PIX_W(8), .LINE_W(LW), .BLUR_SHIFT(SH)) uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol), .in_pix(in_pix),
      .out_valid(out_valid), .out_pix(out_pix), .out_eol(out_eol)
   );

   always #10 clk = ~clk;

   int total = 0, bad = 0, cyc = 0;
   bit mon_on = 0, done = 0;
   int img [NR][LW];
   bit    exp_v [4096];
   int    exp_p [4096];
   bit    exp_e [4096];
   string exp_t [4096];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic fail(string what, int act, int expv);
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
   endtask

   function automatic int pat(int kind, int f, int r, int c);
      case (kind)
         0: return (r * 41 + c * 23 + f * 7) % 256;
         1: return (((r * LW + c) * 149 + f * 61 + 17) * 73) % 256;
         2: return 255;
         default: return ((r + c) % 2 == 1) ? 255 : 0;
      endcase
   endfunction

   function automatic int kraw(int mode, int r, int c);
      int p [3][3];
      int gx, gy;
      for (int i = 0; i < 3; i++)
         for (int j = 0; j < 3; j++)
            p[i][j] = (c - 2 + j < 0) ? 0 : img[r - 2 + i][c - 2 + j];
      case (mode)
         0: return (p[0][0] + p[0][1] + p[0][2] + p[1][0] + p[1][1] + p[1][2]
                    + p[2][0] + p[2][1] + p[2][2]) >> SH;
         1: begin
            gx = p[0][2] + 2 * p[1][2] + p[2][2] - p[0][0] - 2 * p[1][0] - p[2][0];
            gy = p[2][0] + 2 * p[2][1] + p[2][2] - p[0][0] - 2 * p[0][1] - p[0][2];
            return (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
         end
         2: return -2 * p[0][0] - p[0][1] - p[1][0] + p[1][1] + p[1][2]
                   + p[2][1] + 2 * p[2][2] + 128;
         default: return 5 * p[1][1] - p[0][1] - p[1][0] - p[1][2] - p[2][1];
      endcase
   endfunction

   task automatic drive_frame(int mode, int kind, int f, bit swap, bit gaps, string ftag);
      int raw;
      string names [4] = '{"R5 blur", "R6 gradient", "R7 relief", "R8 crisp"};
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < LW; c++)
            img[r][c] = pat(kind, f, r, c);
      for (int r = 0; r < NR; r++) begin
         for (int c = 0; c < LW; c++) begin
            if (gaps && ((r * LW + c) % 3 == 1)) begin
               @(negedge clk);
               in_valid = 1'b0;
               in_sof   = 1'b0;
               in_eol   = 1'b0;
               in_pix   = 8'hA5;
            end
            @(negedge clk);
            mode_sel = (swap && !(r == 0 && c == 0)) ? 2'(mode ^ 1) : 2'(mode);
            in_valid = 1'b1;
            in_sof   = (r == 0 && c == 0);
            in_eol   = (c == LW - 1);
            in_pix   = 8'(img[r][c]);
            if (r >= 2 && (r > 2 || c >= 2)) begin
               raw = kraw(mode, r, c);
               exp_v[cyc + 2] = 1'b1;
               exp_p[cyc + 2] = raw < 0 ? 0 : (raw > 255 ? 255 : raw);
               exp_e[cyc + 2] = (c == LW - 1);
               if (ftag != "")            exp_t[cyc + 2] = ftag;
               else if (raw < 0 || raw > 255) exp_t[cyc + 2] = "R9 clamp";
               else if (c < 2)            exp_t[cyc + 2] = "R4 zero-fill";
               else                       exp_t[cyc + 2] = names[mode];
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eol   = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // output monitor: R2 R3 timing, pixel value, R11 end of line
   always @(negedge clk) begin
      if (mon_on) begin
         total++;
         if (out_valid !== exp_v[cyc])
            fail("R2 R3 out_valid timing", int'(out_valid), int'(exp_v[cyc]));
         else if (exp_v[cyc]) begin
            total++;
            if (int'(out_pix) != exp_p[cyc])
               fail({exp_t[cyc], " out_pix"}, int'(out_pix), exp_p[cyc]);
            total++;
            if (out_eol !== exp_e[cyc])
               fail("R11 out_eol", int'(out_eol), int'(exp_e[cyc]));
         end
         else if (out_eol !== 1'b0) begin
            total++;
            fail("R11 out_eol without valid", int'(out_eol), 0);
         end
      end
   end

   initial begin
      int f = 0;
      for (int i = 0; i < 4096; i++) begin
         exp_v[i] = 1'b0;
         exp_p[i] = 0;
         exp_e[i] = 1'b0;
         exp_t[i] = "";
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      total += 3;
      if (out_valid !== 1'b0) fail("R1 out_valid in reset", int'(out_valid), 0);
      if (out_eol !== 1'b0)   fail("R1 out_eol in reset", int'(out_eol), 0);
      if (out_pix !== 8'd0)   fail("R1 out_pix in reset", int'(out_pix), 0);
      rst_n = 1'b1;
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0) fail("R1 out_valid after reset", int'(out_valid), 0);
      mon_on = 1'b1;
      for (int m = 0; m < 4; m++)
         for (int k = 0; k < 4; k++) begin
            drive_frame(m, k, f, 1'b0, 1'b0, "");
            f++;
         end
      drive_frame(1, 1, f, 1'b1, 1'b0, "R10 mode latch"); f++;
      drive_frame(3, 0, f, 1'b1, 1'b0, "R10 mode latch"); f++;
      drive_frame(3, 1, f, 1'b0, 1'b1, "R12 stall");      f++;
      drive_frame(2, 0, f, 1'b0, 1'b1, "R12 stall");      f++;
      drive_frame(0, 1, f, 1'b0, 1'b0, "");               f++;
      repeat (4) @(negedge clk);
      mon_on = 1'b0;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(64'd200000 * 20);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule